// File: doc/BRIEF.md
# Synchronous Clock-Ratio Qualifier Generator

This block runs in a fast core clock domain. The fast clock is locked to a slower bus clock and runs at an integer multiple of its frequency. A reset-aligned phase counter marks the final fast cycle of every bus cycle with a one-cycle strobe. That strobe does three jobs:

- It loads a bank of capture registers with bus-side data.
- It paces a registered access enable that passes core data onto the bus only while a core-initiated transfer is in progress.
- It commits writes to a one-bit APB control register.

The control register picks the clock handed to the core, either the fast clock or the bus clock. A glitch-free switch makes the change: it gates off the old clock before it enables the new one. A done flag shows when the new clock is running.

Integration notes:

- Reset must be released during the first fast cycle that follows a rising edge of the bus clock. This lets the counter start in step with the bus clock.
- APB transfers are assumed to be timed by the bus clock.

Top module: `ratio_qual_gen`

## Requirements
- R1: The parameter RATIO must be 2, 3 or 4. The fast cycle that begins at a bus-clock rising edge is phase 0, and the first cycle after reset release is phase 0. `qual` is high only in phase RATIO-1, which is the last fast cycle of the bus clock's low phase. It is never high on two cycles in a row, and it is low while reset is active.
- R2: `cap_q` loads `bus_in` on a fast rising edge only when `qual` is high. On every other edge it keeps its value. It is zero after reset.
- R3: `acc_en` loads `core_req` only on edges where `qual` is high. It is therefore constant across a whole bus cycle, and it is low after reset.
- R4: `bus_out` equals `core_data` while `acc_en` is 1 and is all zeros while `acc_en` is 0.
- R5: An APB write with `psel`, `penable` and `pwrite` all high, on an edge where `qual` is high, stores `pwdata[0]` as the clock selection. 1 selects the fast clock and 0 selects the bus clock. The selection resets to 0.
- R6: `prdata` bit 0 returns the stored selection and all other bits read 0.
- R7: The two clock enables are never active together. `clk_core` carries no high pulse shorter than half a fast period.
- R8: `sw_done` is 1 once the selected clock's enable is active and the other enable is off. It is 0 by the second fast edge after the selection changes.
- R9: Once `sw_done` is 1, `clk_core` shows RATIO rising edges per bus cycle with the fast selection and one per bus cycle with the slow selection.
- R10: Write attempts with `penable` low, or with `pwrite` low, leave the selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast core clock |
| clk_slow | input | 1 | Bus clock, synchronous, RATIO times slower |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | IN_W | Data from the bus domain |
| cap_q | output | IN_W | Captured bus data in the fast domain |
| core_req | input | 1 | Core has a bus transfer in progress |
| core_data | input | OUT_W | Core data toward the bus |
| acc_en | output | 1 | Registered access enable, stable per bus cycle |
| bus_out | output | OUT_W | Gated core data toward the bus |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write direction |
| pwdata | input | APB_W | APB write data |
| prdata | output | APB_W | APB read data |
| qual | output | 1 | End-of-bus-cycle strobe |
| clk_core | output | 1 | Clock selected for the core |
| sw_done | output | 1 | Selected clock is active |

## Verification
The assertions check a set of properties on every fast cycle:

- the strobe spacing and that it never repeats back to back;
- the hold and load behaviour of the capture bank and of the access enable;
- the zero output while the access enable is low;
- the zero upper read bits, and that the selection changes only at a strobe;
- that the two clock enables are never active together.

Some behaviours only the bench scenarios can show:

- the strobe falling in the last low-phase cycle of the bus clock;
- the core clock's edge count under each selection;
- the minimum pulse width on the core clock through a switch;
- when the done flag drops and rises;
- that writes with a missing APB control bit are ignored.

// File: rtl/rq_pkg.sv
package rq_pkg;
   typedef enum logic {
      CLK_PICK_SLOW = 1'b0,
      CLK_PICK_FAST = 1'b1
   } clk_pick_e;

   function automatic bit ratio_ok(input int r);
      return (r >= 2) && (r <= 4);
   endfunction
endpackage

// File: rtl/rq_phase.sv
module rq_phase #(
   parameter int RATIO = 3
) (
   input  logic clk_fast,
   input  logic rst_n,
   output logic qual
);
   localparam int CW   = (RATIO > 2) ? $clog2(RATIO) : 1;
   localparam int LAST = RATIO - 1;

   generate
      if (RATIO == 2) begin : g_toggle
         logic ph_q;
         always_ff @(posedge clk_fast or negedge rst_n) begin
            if (!rst_n) ph_q <= 1'b0;
            else        ph_q <= ~ph_q;
         end
         assign qual = ph_q;
      end else begin : g_count
         logic [CW-1:0] ph_q;
         always_ff @(posedge clk_fast or negedge rst_n) begin
            if (!rst_n)                  ph_q <= '0;
            else if (ph_q == CW'(LAST))  ph_q <= '0;
            else                         ph_q <= ph_q + 1'b1;
         end
         assign qual = (ph_q == CW'(LAST));
      end
   endgenerate
endmodule

// File: rtl/rq_capture.sv
module rq_capture #(
   parameter int IN_W = 8
) (
   input  logic            clk_fast,
   input  logic            rst_n,
   input  logic            load,
   input  logic [IN_W-1:0] d,
   output logic [IN_W-1:0] q
);
   generate
      for (genvar b = 0; b < IN_W; b++) begin : g_lane
         always_ff @(posedge clk_fast or negedge rst_n) begin
            if (!rst_n)    q[b] <= 1'b0;
            else if (load) q[b] <= d[b];
         end
      end
   endgenerate
endmodule

// File: rtl/rq_gate.sv
module rq_gate #(
   parameter int OUT_W = 8
) (
   input  logic             clk_fast,
   input  logic             rst_n,
   input  logic             qual,
   input  logic             req,
   input  logic [OUT_W-1:0] d,
   output logic             en,
   output logic [OUT_W-1:0] q
);
   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n)    en <= 1'b0;
      else if (qual) en <= req;
   end

   assign q = d & {OUT_W{en}};
endmodule

// File: rtl/rq_ctrl_reg.sv
module rq_ctrl_reg
   import rq_pkg::*;
#(
   parameter int APB_W = 32
) (
   input  logic             clk_fast,
   input  logic             rst_n,
   input  logic             qual,
   input  logic             psel,
   input  logic             penable,
   input  logic             pwrite,
   input  logic [APB_W-1:0] pwdata,
   output logic [APB_W-1:0] prdata,
   output clk_pick_e        pick
);
   logic wr_hit;
   assign wr_hit = qual & psel & penable & pwrite;

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n)      pick <= CLK_PICK_SLOW;
      else if (wr_hit) pick <= clk_pick_e'(pwdata[0]);
   end

   assign prdata = {{(APB_W-1){1'b0}}, pick};
endmodule

// File: rtl/rq_clksw.sv
module rq_clksw
   import rq_pkg::*;
(
   input  logic      clk_fast,
   input  logic      clk_slow,
   input  logic      rst_n,
   input  clk_pick_e pick,
   output logic      fast_en,
   output logic      slow_en,
   output logic      clk_core,
   output logic      done
);
   logic want_fast;
   logic fast_arm;
   logic slow_arm;

   assign want_fast = (pick == CLK_PICK_FAST);

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) fast_arm <= 1'b0;
      else        fast_arm <= want_fast & ~slow_en;
   end
   always_ff @(negedge clk_fast or negedge rst_n) begin
      if (!rst_n) fast_en <= 1'b0;
      else        fast_en <= fast_arm;
   end

   always_ff @(posedge clk_slow or negedge rst_n) begin
      if (!rst_n) slow_arm <= 1'b0;
      else        slow_arm <= ~want_fast & ~fast_en;
   end
   always_ff @(negedge clk_slow or negedge rst_n) begin
      if (!rst_n) slow_en <= 1'b0;
      else        slow_en <= slow_arm;
   end

   assign clk_core = (clk_fast & fast_en) | (clk_slow & slow_en);

   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= want_fast ? (fast_en & ~slow_en) : (slow_en & ~fast_en);
   end
endmodule

// File: rtl/ratio_qual_gen.sv
module ratio_qual_gen
   import rq_pkg::*;
#(
   parameter int RATIO = 3,
   parameter int IN_W  = 8,
   parameter int OUT_W = 8,
   parameter int APB_W = 32
) (
   input  logic             clk_fast,
   input  logic             clk_slow,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  bus_in,
   output logic [IN_W-1:0]  cap_q,
   input  logic             core_req,
   input  logic [OUT_W-1:0] core_data,
   output logic             acc_en,
   output logic [OUT_W-1:0] bus_out,
   input  logic             psel,
   input  logic             penable,
   input  logic             pwrite,
   input  logic [APB_W-1:0] pwdata,
   output logic [APB_W-1:0] prdata,
   output logic             qual,
   output logic             clk_core,
   output logic             sw_done
);
   generate
      if (!ratio_ok(RATIO)) begin : g_bad_ratio
         $error("ratio_qual_gen: RATIO must be 2, 3 or 4");
      end
      if (IN_W < 1 || OUT_W < 1 || APB_W < 2) begin : g_bad_width
         $error("ratio_qual_gen: width parameters out of range");
      end
   endgenerate

   clk_pick_e pick;
   logic      fast_en;
   logic      slow_en;

   rq_phase #(.RATIO(RATIO)) u_phase (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .qual     (qual)
   );

   rq_capture #(.IN_W(IN_W)) u_cap (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .load     (qual),
      .d        (bus_in),
      .q        (cap_q)
   );

   rq_gate #(.OUT_W(OUT_W)) u_gate (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .qual     (qual),
      .req      (core_req),
      .d        (core_data),
      .en       (acc_en),
      .q        (bus_out)
   );

   rq_ctrl_reg #(.APB_W(APB_W)) u_reg (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .qual     (qual),
      .psel     (psel),
      .penable  (penable),
      .pwrite   (pwrite),
      .pwdata   (pwdata),
      .prdata   (prdata),
      .pick     (pick)
   );

   rq_clksw u_sw (
      .clk_fast (clk_fast),
      .clk_slow (clk_slow),
      .rst_n    (rst_n),
      .pick     (pick),
      .fast_en  (fast_en),
      .slow_en  (slow_en),
      .clk_core (clk_core),
      .done     (sw_done)
   );
endmodule

// File: rtl/ratio_qual_gen_chk.sv
module ratio_qual_gen_chk #(
   parameter int RATIO = 3,
   parameter int IN_W  = 8,
   parameter int OUT_W = 8,
   parameter int APB_W = 32
) (
   input logic             clk_fast,
   input logic             rst_n,
   input logic             qual,
   input logic [IN_W-1:0]  bus_in,
   input logic [IN_W-1:0]  cap_q,
   input logic             acc_en,
   input logic [OUT_W-1:0] bus_out,
   input logic [APB_W-1:0] prdata,
   input logic             fast_en,
   input logic             slow_en
);
   int gap_q;
   always_ff @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n)    gap_q <= 0;
      else if (qual) gap_q <= 0;
      else           gap_q <= gap_q + 1;
   end

   // R1
   qual_spacing_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      qual |-> (gap_q == RATIO - 1));
   // R1
   qual_single_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      qual |=> !qual);
   // R2
   cap_hold_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !qual |=> $stable(cap_q));
   // R2
   cap_load_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      qual |=> (cap_q == $past(bus_in)));
   // R3
   acc_stable_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !qual |=> $stable(acc_en));
   // R4
   gate_zero_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !acc_en |-> (bus_out == '0));
   // R5
   sel_commit_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      !qual |=> $stable(prdata[0]));
   // R6
   rd_upper_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      prdata[APB_W-1:1] == '0);
   // R7
   clk_excl_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
      $onehot0({fast_en, slow_en}));
endmodule

bind ratio_qual_gen ratio_qual_gen_chk #(
   .RATIO(RATIO), .IN_W(IN_W), .OUT_W(OUT_W), .APB_W(APB_W)
) u_chk (
   .clk_fast (clk_fast),
   .rst_n    (rst_n),
   .qual     (qual),
   .bus_in   (bus_in),
   .cap_q    (cap_q),
   .acc_en   (acc_en),
   .bus_out  (bus_out),
   .prdata   (prdata),
   .fast_en  (fast_en),
   .slow_en  (slow_en)
);

// File: tb/ratio_qual_gen_tb_top.sv
`timescale 1ns/1ps
module ratio_qual_gen_tb_top;
   localparam int N     = 3;
   localparam int HI    = (N + 1) / 2;
   localparam int IN_W  = 8;
   localparam int OUT_W = 8;
   localparam int APB_W = 32;

   logic             clk_fast, clk_slow, rst_n;
   logic [IN_W-1:0]  bus_in, cap_q;
   logic             core_req, acc_en;
   logic [OUT_W-1:0] core_data, bus_out;
   logic             psel, penable, pwrite;
   logic [APB_W-1:0] pwdata, prdata;
   logic             qual, clk_core, sw_done;

   int checks = 0;
   int errors = 0;
   int ph = N - 1;
   bit finished = 0;

   ratio_qual_gen #(.RATIO(N), .IN_W(IN_W), .OUT_W(OUT_W), .APB_W(APB_W)) dut_i (
      .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
      .bus_in(bus_in), .cap_q(cap_q), .core_req(core_req), .core_data(core_data),
      .acc_en(acc_en), .bus_out(bus_out), .psel(psel), .penable(penable),
      .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .qual(qual),
      .clk_core(clk_core), .sw_done(sw_done)
   );

   // 50 MHz fast clock, bus clock rises together with phase-0 fast edges
   initial begin
      clk_fast = 0;
      clk_slow = 0;
      forever begin
         #10;
         ph = (ph + 1) % N;
         clk_fast = 1;
         clk_slow = (ph < HI);
         #10;
         clk_fast = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit               exp_q;
   logic [IN_W-1:0]  m_cap;
   bit               m_acc;
   bit               m_sel;
   bit               live_chk;

   always @(negedge clk_fast) exp_q = rst_n && (ph == N - 1);

   always @(posedge clk_fast or negedge rst_n) begin
      if (!rst_n) begin
         m_cap = '0; m_acc = 0; m_sel = 0;
      end else if (exp_q) begin
         m_cap = bus_in;
         m_acc = core_req;
         if (psel && penable && pwrite) m_sel = pwdata[0];
      end
   end

   always @(negedge clk_fast) begin
      if (live_chk && rst_n) begin
         #1;
         chk(qual == exp_q, "R1 qual", qual, exp_q);
         chk(cap_q == m_cap, "R2 cap_q", cap_q, m_cap);
         chk(acc_en == m_acc, "R3 acc_en", acc_en, m_acc);
         chk(bus_out == (m_acc ? core_data : '0), "R4 bus_out", bus_out, m_acc ? core_data : '0);
         chk(prdata == APB_W'(m_sel), "R6 prdata", prdata, m_sel);
      end
   end

   // core clock edge counting and pulse-width tracking (R7, R9)
   int  core_edges = 0;
   time t_rise = 0;
   time min_high = 1000;
   always @(posedge clk_core) begin core_edges++; t_rise = $time; end
   always @(negedge clk_core) if ($time - t_rise < min_high && t_rise > 0) min_high = $time - t_rise;

   task automatic apb_write(input bit v, input bit en_ok, input bit wr_ok);
      @(posedge clk_slow); #3;
      psel = 1; pwrite = wr_ok; penable = 0; pwdata = {{(APB_W-1){1'b1}}, v};
      @(posedge clk_slow); #3;
      penable = en_ok;
      @(posedge clk_slow); #3;
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic switch_to(input bit v);
      apb_write(v, 1, 1);
      @(posedge clk_fast);
      @(negedge clk_fast); #2;
      // R8 done drops within two fast edges of the selection change
      chk(sw_done == 0, "R8 done low after change", sw_done, 0);
      for (int i = 0; i < 4 * N + 8 && !sw_done; i++) @(negedge clk_fast);
      #2;
      chk(sw_done == 1, "R8 done rises", sw_done, 1);
   endtask

   task automatic count_edges(input int exp);
      @(posedge clk_slow); #1;
      core_edges = 0;
      for (int i = 0; i < 4 * N; i++) @(posedge clk_fast);
      #1;
      // R9 edge count follows the selection
      chk(core_edges == exp, "R9 clk_core edges", core_edges, exp);
   endtask

   initial begin
      rst_n = 0; live_chk = 0;
      bus_in = '0; core_req = 0; core_data = '0;
      psel = 0; penable = 0; pwrite = 0; pwdata = '0;
      #55;
      chk(qual == 0 && cap_q == 0 && acc_en == 0 && prdata == 0 && bus_out == 0,
          "R1 R2 R3 R5 reset state", {qual, acc_en, prdata[0]}, 0);
      @(posedge clk_slow); #1;
      rst_n = 1;
      live_chk = 1;
      // capture and gate with several patterns
      for (int k = 0; k < 6 * N; k++) begin
         @(posedge clk_fast); #3;
         bus_in = IN_W'(8'h11 * (k + 1));
         core_data = OUT_W'(8'hA5 ^ k);
         core_req = (k % 4) < 2;
      end
      core_req = 1;
      for (int k = 0; k < 3 * N; k++) begin
         @(posedge clk_fast); #3;
         bus_in = ~bus_in;
         core_data = core_data + 8'h3;
      end
      core_req = 0;
      for (int i = 0; i < 4 * N + 8 && !sw_done; i++) @(negedge clk_fast);
      #2;
      chk(sw_done == 1, "R8 slow clock active after reset", sw_done, 1);
      count_edges(4);
      // R10 writes lacking penable or pwrite are ignored
      apb_write(1, 0, 1);
      @(negedge clk_fast); #2;
      chk(prdata[0] == 0, "R10 no penable", prdata[0], 0);
      apb_write(1, 1, 0);
      @(negedge clk_fast); #2;
      chk(prdata[0] == 0, "R10 no pwrite", prdata[0], 0);
      // R5 switch to fast
      switch_to(1);
      chk(prdata[0] == 1, "R5 fast selected", prdata[0], 1);
      count_edges(4 * N);
      // R5 back to slow
      switch_to(0);
      chk(prdata[0] == 0, "R5 slow selected", prdata[0], 0);
      count_edges(4);
      switch_to(1);
      count_edges(4 * N);
      // R7 no runt high pulse on the core clock
      chk(min_high >= 10, "R7 min high time", min_high, 10);
      live_chk = 0;
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule